// File: doc/BRIEF.md
# Backup Supply Switchover Controller

This block decides whether the supply rail that keeps a retained memory alive is fed from the main supply or from a backup battery. It does not see voltages. Three comparator results arrive as digital flags: the main supply is above its reset threshold, the main supply is above the battery, and the battery has fallen under its low-battery limit. The block first synchronizes these flags. It then drives two switch enables, one for the main path and one for the battery path, together with a status bit that reports battery operation.

The battery path is taken only when the main supply is not above the battery and, in addition, either the main supply is below its threshold or the battery is flagged low. This lets a battery whose voltage is higher than a healthy main supply stay disconnected. Battery operation ends as soon as either recovery condition appears. Every change of path passes through a dead band in which both enables are low, so the two switches are never closed together. After reset both enables stay low until the synchronized flags are valid. The block then closes the selected path directly, with no dead band.

Top module: `bkup_supply_sel`

## Requirements
- R1: With the battery not flagged low, the battery path is selected when the main supply is below its threshold and not above the battery.
- R2: While the main supply is above its threshold and the battery is not flagged low, the main path stays selected, including when the battery is higher than the main supply.
- R3: In battery operation, the main path is restored once the main supply rises above the battery, even while it is still below its threshold.
- R4: In battery operation, with the battery not flagged low, the main path is restored once the main supply rises above its threshold, even while the battery is still higher.
- R5: When the low-battery override is built in (LOWBAT_OVERRIDE=1) and the battery is flagged low, the battery path is selected whenever the main supply is not above the battery, whatever the threshold flag says.
- R6: The main enable and the battery enable are never high in the same cycle.
- R7: On every change between paths, both enables are low for exactly GAP_CYCLES clock cycles before the new enable rises.
- R8: When an input change is sampled at clock edge k, the old enable falls after edge k+SYNC_STAGES and the new enable rises after edge k+SYNC_STAGES+GAP_CYCLES.
- R9: During reset and for SYNC_STAGES edges after its release, both enables are low. At the next edge the selected path closes directly, and the other enable never rises.
- R10: The status output on_bat_o is high exactly when the battery enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, synchronous to clk_i |
| main_ok_i | input | 1 | Main supply above its reset threshold (asynchronous flag) |
| main_over_bat_i | input | 1 | Main supply above battery voltage (asynchronous flag) |
| bat_low_i | input | 1 | Battery below its low-battery limit (asynchronous flag) |
| en_main_o | output | 1 | Closes the switch from the main supply to the retained rail |
| en_bat_o | output | 1 | Closes the switch from the battery to the retained rail |
| on_bat_o | output | 1 | Status: retained rail is fed from the battery |

## Verification
The bench builds the block with SYNC_STAGES=3, GAP_CYCLES=2 and the low-battery override enabled. Because the synchronizer depth differs from the dead-band length, a latency error in either one appears at its own cycle. The two-cycle dead band also exposes a counter that ends its gap one cycle early or one cycle late. With the override built in, the low-battery entry and its return path (R5) can be reached.

// File: rtl/bss_pkg.sv
package bss_pkg;

   typedef enum logic [2:0] {
      ST_START = 3'd0,
      ST_MAIN  = 3'd1,
      ST_GAP_B = 3'd2,
      ST_BAT   = 3'd3,
      ST_GAP_M = 3'd4
   } sel_state_e;

   localparam int unsigned FLAG_OK  = 0;
   localparam int unsigned FLAG_GT  = 1;
   localparam int unsigned FLAG_LOW = 2;
   localparam int unsigned N_FLAGS  = 3;

endpackage

// File: rtl/bss_sync.sv
module bss_sync #(
   parameter int unsigned WIDTH  = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   logic [WIDTH-1:0] stg_q [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk_i) begin
            if (!rst_ni) stg_q[g] <= '0;
            else         stg_q[g] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i) begin
            if (!rst_ni) stg_q[g] <= '0;
            else         stg_q[g] <= stg_q[g-1];
         end
      end
   end

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/bss_policy.sv
module bss_policy #(
   parameter bit LOWBAT_OVERRIDE = 1'b1
) (
   input  logic main_ok_i,
   input  logic main_over_bat_i,
   input  logic bat_low_i,
   output logic want_bat_o
);

   // Battery is only a candidate while it is above the main supply.
   logic bat_higher;
   assign bat_higher = !main_over_bat_i;

   if (LOWBAT_OVERRIDE) begin : g_override
      assign want_bat_o = bat_higher && (!main_ok_i || bat_low_i);
   end else begin : g_plain
      logic unused_low;
      assign unused_low = bat_low_i;
      assign want_bat_o = bat_higher && !main_ok_i;
   end

endmodule

// File: rtl/bss_sequencer.sv
module bss_sequencer
   import bss_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned GAP_CYCLES  = 1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic want_bat_i,
   output logic en_main_o,
   output logic en_bat_o,
   output logic on_bat_o
);

   localparam int unsigned CNT_MAX = (SYNC_STAGES > GAP_CYCLES) ? SYNC_STAGES : GAP_CYCLES;
   localparam int unsigned CW      = $clog2(CNT_MAX + 1);
   localparam logic [CW-1:0] GAP_LAST   = CW'(GAP_CYCLES - 1);
   localparam logic [CW-1:0] START_LAST = CW'(SYNC_STAGES);

   sel_state_e    st_q, st_d;
   logic [CW-1:0] cnt_q, cnt_d;
   logic          en_main_q, en_bat_q;

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      unique case (st_q)
         ST_START: begin
            if (cnt_q == START_LAST) begin
               st_d  = want_bat_i ? ST_BAT : ST_MAIN;
               cnt_d = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         ST_MAIN: begin
            if (want_bat_i) begin
               st_d  = ST_GAP_B;
               cnt_d = '0;
            end
         end
         ST_GAP_B: begin
            if (cnt_q == GAP_LAST) begin
               st_d  = ST_BAT;
               cnt_d = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         ST_BAT: begin
            if (!want_bat_i) begin
               st_d  = ST_GAP_M;
               cnt_d = '0;
            end
         end
         ST_GAP_M: begin
            if (cnt_q == GAP_LAST) begin
               st_d  = ST_MAIN;
               cnt_d = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         default: begin
            st_d  = ST_START;
            cnt_d = '0;
         end
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         st_q      <= ST_START;
         cnt_q     <= '0;
         en_main_q <= 1'b0;
         en_bat_q  <= 1'b0;
      end else begin
         st_q      <= st_d;
         cnt_q     <= cnt_d;
         en_main_q <= (st_d == ST_MAIN);
         en_bat_q  <= (st_d == ST_BAT);
      end
   end

   assign en_main_o = en_main_q;
   assign en_bat_o  = en_bat_q;
   assign on_bat_o  = (st_q == ST_BAT);

   a_r9_quiet_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_START) |-> (!en_main_q && !en_bat_q));

   a_r7_bat_after_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(en_bat_q) |-> $past(!en_main_q));

   a_r7_main_after_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(en_main_q) |-> $past(!en_bat_q));

   a_r7_main_off_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(en_main_q) |-> !en_bat_q);

   a_r8_gap_completes: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_GAP_B && cnt_q == GAP_LAST) |=> en_bat_q);

endmodule

// File: rtl/bkup_supply_sel.sv
module bkup_supply_sel
   import bss_pkg::*;
#(
   parameter int unsigned SYNC_STAGES     = 2,
   parameter int unsigned GAP_CYCLES      = 1,
   parameter bit          LOWBAT_OVERRIDE = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic main_ok_i,
   input  logic main_over_bat_i,
   input  logic bat_low_i,
   output logic en_main_o,
   output logic en_bat_o,
   output logic on_bat_o
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (GAP_CYCLES < 1) begin : g_bad_gap
      $error("GAP_CYCLES must be at least 1");
   end

   logic [N_FLAGS-1:0] flags_raw, flags_s;
   logic               want_bat;

   assign flags_raw[FLAG_OK]  = main_ok_i;
   assign flags_raw[FLAG_GT]  = main_over_bat_i;
   assign flags_raw[FLAG_LOW] = bat_low_i;

   bss_sync #(.WIDTH(N_FLAGS), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (flags_raw),
      .q_o    (flags_s)
   );

   bss_policy #(.LOWBAT_OVERRIDE(LOWBAT_OVERRIDE)) u_policy (
      .main_ok_i       (flags_s[FLAG_OK]),
      .main_over_bat_i (flags_s[FLAG_GT]),
      .bat_low_i       (flags_s[FLAG_LOW]),
      .want_bat_o      (want_bat)
   );

   bss_sequencer #(.SYNC_STAGES(SYNC_STAGES), .GAP_CYCLES(GAP_CYCLES)) u_seq (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .want_bat_i (want_bat),
      .en_main_o  (en_main_o),
      .en_bat_o   (en_bat_o),
      .on_bat_o   (on_bat_o)
   );

   a_r6_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({en_main_o, en_bat_o}));

   a_r10_status_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      on_bat_o |-> en_bat_o);

   a_r2_hold_main: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_main_o && flags_s[FLAG_OK] && !flags_s[FLAG_LOW]) |=> !en_bat_o);

endmodule

// File: tb/bkup_supply_sel_tb_top.sv
module bkup_supply_sel_tb_top;

   localparam int S = 3;
   localparam int G = 2;
   localparam int SETTLE = 12;
   localparam int NV = 10;

   // {main_ok, main_over_bat, bat_low, expect_battery}
   localparam logic [3:0] VEC [NV] = '{
      4'b1100, 4'b1000, 4'b0001, 4'b0100, 4'b0001,
      4'b1000, 4'b1011, 4'b1110, 4'b0110, 4'b0011
   };

   logic clk = 1'b0;
   logic rst_ni = 1'b0;
   logic ok = 1'b1, gt = 1'b1, low = 1'b0;
   logic en_main, en_bat, on_bat;

   int n_chk = 0;
   int n_fail = 0;
   int overlap = 0;
   int stat_err = 0;

   always #5 clk = ~clk;

   bkup_supply_sel #(.SYNC_STAGES(S), .GAP_CYCLES(G), .LOWBAT_OVERRIDE(1'b1)) dut_i (
      .clk_i           (clk),
      .rst_ni          (rst_ni),
      .main_ok_i       (ok),
      .main_over_bat_i (gt),
      .bat_low_i       (low),
      .en_main_o       (en_main),
      .en_bat_o        (en_bat),
      .on_bat_o        (on_bat)
   );

   always @(negedge clk) begin
      if (rst_ni) begin
         if (en_main && en_bat) overlap++;
         if (on_bat !== en_bat) stat_err++;
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // enables packed as {en_main, en_bat}
   function automatic int ens();
      return {30'd0, en_main, en_bat};
   endfunction

   initial begin
      #2000000;
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      // R9: reset with a healthy main supply
      step(3);
      chk("R9 in reset", ens(), 0);
      rst_ni = 1'b1;
      step(S);
      chk("R9 quiet after release", ens(), 0);
      step(1);
      chk("R9 main closes directly", ens(), 2);

      // R7/R8: main -> battery timing
      ok = 1'b0; gt = 1'b0; low = 1'b0;
      step(S);
      chk("R8 main held during sync", ens(), 2);
      step(1);
      chk("R7 gap start", ens(), 0);
      step(G - 1);
      chk("R7 gap end", ens(), 0);
      step(1);
      chk("R8 battery closes", ens(), 1);

      // R7/R8: battery -> main timing (R3 trigger)
      gt = 1'b1;
      step(S);
      chk("R8 battery held during sync", ens(), 1);
      step(1);
      chk("R7 gap start back", ens(), 0);
      step(G - 1);
      chk("R7 gap end back", ens(), 0);
      step(1);
      chk("R3 main closes", ens(), 2);

      // Table of settled selections
      for (int v = 0; v < NV; v++) begin
         ok  = VEC[v][3];
         gt  = VEC[v][2];
         low = VEC[v][1];
         step(SETTLE);
         chk($sformatf("R1 R2 R3 R4 R5 vector %0d", v), ens(), VEC[v][0] ? 1 : 2);
         chk($sformatf("R10 status vector %0d", v), int'(on_bat), int'(VEC[v][0]));
      end

      // R9: reset with battery selected, no main pulse
      @(negedge clk);
      rst_ni = 1'b0;
      ok = 1'b0; gt = 1'b0; low = 1'b0;
      step(2);
      chk("R9 in reset second", ens(), 0);
      rst_ni = 1'b1;
      for (int i = 0; i < S; i++) begin
         step(1);
         chk("R9 quiet no main", ens(), 0);
      end
      step(1);
      chk("R9 battery closes directly", ens(), 1);

      chk("R6 never both enabled", overlap, 0);
      chk("R10 status matches battery enable", stat_err, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule